// File: doc/BRIEF.md
# Single-Wire Serial Write-Command Decoder

This block sits behind a byte receiver on a shared half-duplex serial line. It turns the byte stream into register write commands. Every byte the receiver completes arrives as a one-cycle strobe with its data. The decoder collects the bytes into command frames and checks the leading sync pattern, the target node address and an 8-bit CRC. A valid write frame aimed at this node produces a one-cycle register-write strobe with a 7-bit register address and a 32-bit value. An 8-bit rolling count of accepted writes lets the host confirm that its writes arrived. Read-request frames are parsed for length and CRC so that the stream stays aligned, but they never produce a write and never change the count.

The decoder recovers from errors by itself. It measures time in bit periods, using the period the receiver reports for the most recent good frame. A frame that stalls between bytes for too long is dropped. Any error in the stream makes the decoder deaf to traffic until the line has been quiet long enough: a stall, a receiver glitch, a framing error, a bad sync nibble or a CRC mismatch. This gives the host a simple way to force resynchronisation: it stops sending for a short while and then starts again.

Top module: `uwd_write_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it, `wr_stb` is 0 and `wr_count` is 0.
- R2: A write frame has 8 bytes in this order:
  - byte 0: sync in bits 3:0, which must equal 4'b0101; bits 7:4 are ignored.
  - byte 1: node address.
  - byte 2: bit 7 = 1 marks a write; bits 6:0 are the register address.
  - bytes 3 to 6: data, most significant byte first.
  - byte 7: CRC.
  A valid matching write raises `wr_stb` for exactly one cycle, starting on the clock edge that accepts the CRC byte. `wr_addr` and `wr_data` carry the frame's fields during that cycle.
- R3: The CRC is CRC-8 with a parameter polynomial (default 8'h07) and initial value 0. It covers every byte before the CRC byte, taken in line order. Each byte is fed least significant bit first into a left-shifting register. The ignored sync-byte bits are included. On a mismatch the frame gives no write and recovery starts.
- R4: A frame matches when its node address equals `slave_addr_cfg + addr_inc`, modulo 256. A well-formed frame that does not match is consumed with no write and no count change, and the next frame is accepted without any idle period.
- R5: `wr_count` rises by 1 on each accepted write and wraps from 255 to 0.
- R6: A frame whose byte 2 has bit 7 = 0 is a 4-byte read request, with the CRC in byte 3 covering bytes 0 to 2. It gives no write and leaves `wr_count` unchanged. The next frame may follow at once.
- R7: When more than 63 reference bit periods pass between two byte strobes of one frame, the partial frame is discarded and recovery starts.
- R8: The reference bit period is the value of `bit_period` sampled when the last CRC-valid frame ended. Until the first such frame, the live `bit_period` value is used.
- R9: During recovery all byte strobes are ignored. Recovery ends once `line_idle` has been high, with no glitch, for 12 reference bit periods without a break.
- R10: Each of the following is handled like a CRC error: a byte flagged with `rx_frame_err`, a pulse on `rx_glitch` while frames are being decoded, or a wrong sync nibble in byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is complete |
| rx_data | input | 8 | Received byte, valid with `rx_valid` |
| rx_frame_err | input | 1 | Stop-bit error on the byte strobed with `rx_valid` |
| rx_glitch | input | 1 | One-cycle pulse: the receiver saw a too-short pulse on the line |
| bit_period | input | PER_W | Measured bit period in clock cycles, from the receiver |
| line_idle | input | 1 | High while the line rests at its idle level |
| slave_addr_cfg | input | 8 | Configured node address |
| addr_inc | input | 1 | Adds one to the configured node address |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 7 | Register address of the write |
| wr_data | output | 32 | Write data |
| wr_count | output | CNT_W | Rolling count of accepted writes |

## Verification
The hardest state to reach from the ports is a reference bit period that differs from the live `bit_period` input, because the latch only loads at the end of a good frame. To reach it, the stimulus first completes a good frame at one period and then raises the input to five times that value. It then stalls a partial frame past the old limit and expects the frame to be dropped. Next, a good frame at the new period loads the latch, and a stall that would have timed out under the old limit is accepted. Holding the decoder inside recovery is also targeted: an error is followed straight away by a valid frame with only short idle gaps, and that frame must vanish.

// File: rtl/uwd_pkg.sv
package uwd_pkg;

    localparam int unsigned BYTE_W          = 8;
    localparam int unsigned DATA_W          = 32;
    localparam int unsigned RADDR_W         = 7;
    localparam int unsigned IDX_W           = 3;
    localparam int unsigned WR_LEN          = 8;
    localparam int unsigned RD_LEN          = 4;
    localparam int unsigned FIRST_DATA_IDX  = 3;
    localparam int unsigned DATA_BYTES      = DATA_W / BYTE_W;
    localparam int unsigned GAP_BIT_TIMES   = 63;
    localparam int unsigned IDLE_BIT_TIMES  = 12;
    localparam logic [3:0]  SYNC_PATTERN    = 4'b0101;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_RECOVER = 1'b1
    } dec_state_e;

    typedef enum logic [2:0] {
        ERR_NONE,
        ERR_GLITCH,
        ERR_GAP,
        ERR_FRAME,
        ERR_SYNC,
        ERR_CRC
    } err_cause_e;

    typedef struct packed {
        logic [BYTE_W-1:0]  slave;
        logic               is_write;
        logic [RADDR_W-1:0] reg_addr;
    } dg_header_t;

    typedef struct packed {
        logic [RADDR_W-1:0] addr;
        logic [DATA_W-1:0]  data;
    } reg_write_t;

    function automatic logic [BYTE_W-1:0] crc8_step(
        input logic [BYTE_W-1:0] crc,
        input logic [BYTE_W-1:0] din,
        input logic [BYTE_W-1:0] poly
    );
        logic [BYTE_W-1:0] c;
        c = crc;
        for (int i = 0; i < BYTE_W; i++) begin
            if (c[BYTE_W-1] ^ din[i])
                c = {c[BYTE_W-2:0], 1'b0} ^ poly;
            else
                c = {c[BYTE_W-2:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/uwd_crc_acc.sv
module uwd_crc_acc
    import uwd_pkg::*;
#(
    parameter logic [BYTE_W-1:0] POLY = 8'h07
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              first,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] crc_q
);

    logic [BYTE_W-1:0] seed;

    assign seed = first ? '0 : crc_q;

    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= '0;
        else if (en)
            crc_q <= crc8_step(seed, din, POLY);
    end

endmodule

// File: rtl/uwd_timer.sv
module uwd_timer
    import uwd_pkg::*;
#(
    parameter int unsigned PER_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period,
    input  logic             gap_arm,
    input  logic             byte_evt,
    input  logic             idle_arm,
    input  logic             idle_ok,
    output logic             gap_expired,
    output logic             idle_done
);

    localparam int unsigned GAP_W  = PER_W + 6;
    localparam int unsigned IDLE_W = PER_W + 4;

    logic [GAP_W-1:0]  gap_cnt_q;
    logic [GAP_W-1:0]  gap_limit;
    logic [IDLE_W-1:0] idle_cnt_q;
    logic [IDLE_W-1:0] idle_limit;

    assign gap_limit  = GAP_W'(period) * GAP_W'(GAP_BIT_TIMES);
    assign idle_limit = IDLE_W'(period) * IDLE_W'(IDLE_BIT_TIMES);

    always_ff @(posedge clk) begin
        if (rst)
            gap_cnt_q <= '0;
        else if (!gap_arm || byte_evt)
            gap_cnt_q <= '0;
        else if (gap_cnt_q != '1)
            gap_cnt_q <= gap_cnt_q + GAP_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            idle_cnt_q <= '0;
        else if (!idle_arm || !idle_ok)
            idle_cnt_q <= '0;
        else if (idle_cnt_q != '1)
            idle_cnt_q <= idle_cnt_q + IDLE_W'(1);
    end

    assign gap_expired = gap_arm && (gap_cnt_q >= gap_limit);
    assign idle_done   = idle_arm && (idle_cnt_q >= idle_limit);

endmodule

// File: rtl/uwd_fields.sv
module uwd_fields
    import uwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] din,
    output dg_header_t        hdr,
    output logic [DATA_W-1:0] word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr <= '0;
        end else if (take) begin
            if (idx == IDX_W'(1))
                hdr.slave <= din;
            if (idx == IDX_W'(2)) begin
                hdr.is_write <= din[BYTE_W-1];
                hdr.reg_addr <= din[RADDR_W-1:0];
            end
        end
    end

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_slot
        logic [BYTE_W-1:0] slot_q;

        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (take && idx == IDX_W'(FIRST_DATA_IDX + g))
                slot_q <= din;
        end

        assign word[DATA_W-1-BYTE_W*g -: BYTE_W] = slot_q;
    end

endmodule

// File: rtl/uwd_write_decoder.sv
module uwd_write_decoder
    import uwd_pkg::*;
#(
    parameter int unsigned       PER_W    = 12,
    parameter int unsigned       CNT_W    = 8,
    parameter logic [BYTE_W-1:0] CRC_POLY = 8'h07
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic [BYTE_W-1:0]  rx_data,
    input  logic               rx_frame_err,
    input  logic               rx_glitch,
    input  logic [PER_W-1:0]   bit_period,
    input  logic               line_idle,
    input  logic [BYTE_W-1:0]  slave_addr_cfg,
    input  logic               addr_inc,
    output logic               wr_stb,
    output logic [RADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic [CNT_W-1:0]   wr_count
);

    dec_state_e        st_q;
    logic [IDX_W-1:0]  idx_q;
    logic [PER_W-1:0]  ref_q;
    logic              ref_valid_q;
    logic [PER_W-1:0]  eff_period;
    logic [BYTE_W-1:0] my_addr;
    logic [BYTE_W-1:0] crc_q;
    logic              gap_expired;
    logic              idle_done;
    logic              byte_take;
    logic              last_byte;
    logic              field_take;
    logic              good_end;
    err_cause_e        cause;
    dg_header_t        hdr;
    logic [DATA_W-1:0] data_word;
    reg_write_t        wr_q;

    assign eff_period = ref_valid_q ? ref_q : bit_period;
    assign my_addr    = slave_addr_cfg + BYTE_W'(addr_inc);
    assign byte_take  = rx_valid && (st_q == ST_RUN);
    assign last_byte  = (idx_q == IDX_W'(WR_LEN - 1)) ||
                        ((idx_q == IDX_W'(RD_LEN - 1)) && !hdr.is_write);

    always_comb begin
        cause = ERR_NONE;
        if (st_q == ST_RUN) begin
            if (rx_glitch)
                cause = ERR_GLITCH;
            else if (gap_expired)
                cause = ERR_GAP;
            else if (rx_valid) begin
                if (rx_frame_err)
                    cause = ERR_FRAME;
                else if (idx_q == '0 && rx_data[3:0] != SYNC_PATTERN)
                    cause = ERR_SYNC;
                else if (last_byte && rx_data != crc_q)
                    cause = ERR_CRC;
            end
        end
    end

    assign field_take = byte_take && (cause == ERR_NONE);
    assign good_end   = field_take && last_byte;

    uwd_crc_acc #(.POLY(CRC_POLY)) i_crc (
        .clk   (clk),
        .rst   (rst),
        .en    (field_take),
        .first (idx_q == '0),
        .din   (rx_data),
        .crc_q (crc_q)
    );

    uwd_fields i_fields (
        .clk  (clk),
        .rst  (rst),
        .take (field_take),
        .idx  (idx_q),
        .din  (rx_data),
        .hdr  (hdr),
        .word (data_word)
    );

    uwd_timer #(.PER_W(PER_W)) i_timer (
        .clk         (clk),
        .rst         (rst),
        .period      (eff_period),
        .gap_arm     ((st_q == ST_RUN) && (idx_q != '0)),
        .byte_evt    (rx_valid),
        .idle_arm    (st_q == ST_RECOVER),
        .idle_ok     (line_idle && !rx_glitch),
        .gap_expired (gap_expired),
        .idle_done   (idle_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_RUN;
            idx_q       <= '0;
            ref_q       <= '0;
            ref_valid_q <= 1'b0;
            wr_stb      <= 1'b0;
            wr_q        <= '0;
            wr_count    <= '0;
        end else begin
            wr_stb <= 1'b0;
            case (st_q)
                ST_RUN: begin
                    if (cause != ERR_NONE) begin
                        st_q  <= ST_RECOVER;
                        idx_q <= '0;
                    end else if (good_end) begin
                        idx_q       <= '0;
                        ref_q       <= bit_period;
                        ref_valid_q <= 1'b1;
                        if (hdr.is_write && hdr.slave == my_addr) begin
                            wr_stb    <= 1'b1;
                            wr_q.addr <= hdr.reg_addr;
                            wr_q.data <= data_word;
                            wr_count  <= wr_count + CNT_W'(1);
                        end
                    end else if (byte_take) begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_RECOVER: begin
                    if (idle_done) begin
                        st_q  <= ST_RUN;
                        idx_q <= '0;
                    end
                end
                default: st_q <= ST_RUN;
            endcase
        end
    end

    assign wr_addr = wr_q.addr;
    assign wr_data = wr_q.data;

endmodule

// File: rtl/uwd_checker.sv
module uwd_checker #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             wr_stb,
    input logic [CNT_W-1:0] wr_count,
    input logic             in_recover,
    input logic             gap_expired,
    input logic             idle_done,
    input logic [7:0]       slave_seen,
    input logic [7:0]       my_addr
);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_count != $past(wr_count)) |-> (wr_stb && wr_count == $past(wr_count) + CNT_W'(1)));

    assert_stb_single_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    assert_stb_after_byte_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(rx_valid));

    assert_addr_match_R4: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> ($past(slave_seen) == $past(my_addr)));

    assert_gap_to_recover_R7: assert property (@(posedge clk) disable iff (rst)
        gap_expired |=> in_recover);

    assert_deaf_in_recovery_R9: assert property (@(posedge clk) disable iff (rst)
        (in_recover && rx_valid) |=> !wr_stb);

    assert_exit_needs_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(in_recover) |-> $past(idle_done));

endmodule

bind uwd_write_decoder uwd_checker #(.CNT_W(CNT_W)) i_uwd_checker (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .wr_stb      (wr_stb),
    .wr_count    (wr_count),
    .in_recover  (st_q == ST_RECOVER),
    .gap_expired (gap_expired),
    .idle_done   (idle_done),
    .slave_seen  (hdr.slave),
    .my_addr     (my_addr)
);

// File: tb/test_uwd_write_decoder.sv
`timescale 1ns/1ps
module test_uwd_write_decoder;

    localparam int          PER_W    = 12;
    localparam logic [7:0]  POLY     = 8'h07;
    localparam int          BYTE_CYC = 40;
    localparam int          SGAP     = 2;

    logic             clk = 1'b0;
    logic             rst;
    logic             rx_valid, rx_frame_err, rx_glitch, line_idle, addr_inc;
    logic [7:0]       rx_data, slave_addr_cfg;
    logic [PER_W-1:0] bit_period;
    logic             wr_stb;
    logic [6:0]       wr_addr;
    logic [31:0]      wr_data;
    logic [7:0]       wr_count;

    always #2.5 clk = ~clk;

    uwd_write_decoder #(.PER_W(PER_W), .CNT_W(8), .CRC_POLY(POLY)) i_uwd_write_decoder (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_frame_err(rx_frame_err), .rx_glitch(rx_glitch), .bit_period(bit_period),
        .line_idle(line_idle), .slave_addr_cfg(slave_addr_cfg), .addr_inc(addr_inc),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .wr_count(wr_count)
    );

    int          tests = 0;
    int          fails = 0;
    int          mon_cnt = 0;
    int          mon_base = 0;
    logic [6:0]  mon_addr;
    logic [31:0] mon_data;
    logic [7:0]  exp_cnt = 8'd0;
    logic [7:0]  fr [8];
    bit          done = 0;

    always @(negedge clk) begin
        if (!rst && wr_stb) begin
            mon_cnt  <= mon_cnt + 1;
            mon_addr <= wr_addr;
            mon_data <= wr_data;
        end
    end

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input int n);
        logic [7:0] c = 8'h00;
        for (int k = 0; k < n; k++)
            for (int i = 0; i < 8; i++)
                c = (c[7] ^ fr[k][i]) ? ({c[6:0], 1'b0} ^ POLY) : {c[6:0], 1'b0};
        return c;
    endfunction

    task automatic make_write(input logic [7:0] sl, input logic [6:0] ra,
                              input logic [31:0] d, input logic [3:0] resv);
        fr[0] = {resv, 4'b0101};
        fr[1] = sl;
        fr[2] = {1'b1, ra};
        fr[3] = d[31:24];
        fr[4] = d[23:16];
        fr[5] = d[15:8];
        fr[6] = d[7:0];
        fr[7] = ref_crc(7);
    endtask

    task automatic make_read(input logic [7:0] sl, input logic [6:0] ra);
        fr[0] = 8'h05;
        fr[1] = sl;
        fr[2] = {1'b0, ra};
        fr[3] = ref_crc(3);
    endtask

    task automatic idle(input int n);
        line_idle = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit ferr, input int gap);
        line_idle = 1'b0;
        repeat (BYTE_CYC - 1) @(negedge clk);
        rx_valid     = 1'b1;
        rx_data      = b;
        rx_frame_err = ferr;
        @(negedge clk);
        rx_valid     = 1'b0;
        rx_frame_err = 1'b0;
        line_idle    = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_frame(input int n, input int ferr_at, input int glitch_after,
                              input int long_after, input int long_gap);
        mon_base = mon_cnt;
        for (int i = 0; i < n; i++) begin
            send_byte(fr[i], i == ferr_at, (i == long_after) ? long_gap : SGAP);
            if (i == glitch_after) begin
                rx_glitch = 1'b1;
                @(negedge clk);
                rx_glitch = 1'b0;
            end
        end
    endtask

    task automatic expect_res(input string req, input int nwr,
                              input logic [6:0] a, input logic [31:0] d);
        repeat (2) @(negedge clk);
        chk({req, " write count"}, 64'(mon_cnt - mon_base), 64'(nwr));
        if (nwr > 0) begin
            chk({req, " addr"}, 64'(mon_addr), 64'(a));
            chk({req, " data"}, 64'(mon_data), 64'(d));
        end
        chk({req, " wr_count"}, 64'(wr_count), 64'(exp_cnt));
    endtask

    task automatic good_write(input string req, input logic [7:0] sl,
                              input logic [6:0] ra, input logic [31:0] d);
        make_write(sl, ra, d, 4'($urandom));
        send_frame(8, -1, -1, -1, 0);
        exp_cnt = exp_cnt + 8'd1;
        expect_res(req, 1, ra, d);
    endtask

    initial begin
        logic [6:0]  ra;
        logic [31:0] d;
        int          kind;
        void'($urandom(32'd20250611));
        rst = 1'b1; rx_valid = 0; rx_frame_err = 0; rx_glitch = 0; rx_data = 0;
        line_idle = 1'b1; addr_inc = 0; slave_addr_cfg = 8'h2C; bit_period = 12'd4;
        repeat (5) @(negedge clk);
        chk("R1 stb in reset", 64'(wr_stb), 64'd0);
        chk("R1 count in reset", 64'(wr_count), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 stb after reset", 64'(wr_stb), 64'd0);
        chk("R1 count after reset", 64'(wr_count), 64'd0);

        // R2 basic writes, R3 reserved nibble included in CRC
        good_write("R2 write A", 8'h2C, 7'h11, 32'hDEADBEEF);
        good_write("R2 write B", 8'h2C, 7'h7F, 32'h00000001);
        make_write(8'h2C, 7'h22, 32'h12345678, 4'h0);
        fr[0] = 8'hA5;
        send_frame(8, -1, -1, -1, 0);
        expect_res("R3 reserved bits in crc", 0, 0, 0);
        idle(60);
        make_write(8'h2C, 7'h23, 32'hCAFEF00D, 4'hA);
        send_frame(8, -1, -1, -1, 0);
        exp_cnt++;
        expect_res("R3 reserved nibble ok", 1, 7'h23, 32'hCAFEF00D);

        // R3 bad crc followed at once by a good frame: ignored (R9)
        make_write(8'h2C, 7'h01, 32'h11111111, 4'h0);
        fr[7] = fr[7] ^ 8'h01;
        send_frame(8, -1, -1, -1, 0);
        expect_res("R3 crc mismatch", 0, 0, 0);
        make_write(8'h2C, 7'h02, 32'h22222222, 4'h0);
        send_frame(8, -1, -1, -1, 0);
        expect_res("R9 deaf without idle", 0, 0, 0);
        idle(60);
        good_write("R9 after idle", 8'h2C, 7'h03, 32'h33333333);

        // R4 address match with increment pin
        addr_inc = 1'b1;
        make_write(8'h2C, 7'h04, 32'h44444444, 4'h0);
        send_frame(8, -1, -1, -1, 0);
        expect_res("R4 base addr rejected with inc", 0, 0, 0);
        good_write("R4 incremented addr no idle", 8'h2D, 7'h05, 32'h55555555);
        slave_addr_cfg = 8'hFF;
        good_write("R4 addr wrap", 8'h00, 7'h06, 32'h66666666);
        slave_addr_cfg = 8'h2C;
        addr_inc = 1'b0;

        // R6 read request then immediate write
        make_read(8'h2C, 7'h10);
        send_frame(4, -1, -1, -1, 0);
        expect_res("R6 read no write", 0, 0, 0);
        good_write("R6 write right after read", 8'h2C, 7'h12, 32'hA5A55A5A);

        // R10 frame error, glitch, bad sync
        make_write(8'h2C, 7'h08, 32'h88888888, 4'h0);
        send_frame(8, 3, -1, -1, 0);
        expect_res("R10 frame error", 0, 0, 0);
        idle(60);
        make_write(8'h2C, 7'h09, 32'h99999999, 4'h0);
        send_frame(8, -1, 3, -1, 0);
        expect_res("R10 glitch", 0, 0, 0);
        idle(60);
        make_write(8'h2C, 7'h0A, 32'hAAAAAAAA, 4'h0);
        fr[0] = 8'h03;
        fr[7] = ref_crc(7);
        send_frame(8, -1, -1, -1, 0);
        expect_res("R10 bad sync", 0, 0, 0);
        idle(60);
        good_write("R10 recovered", 8'h2C, 7'h0B, 32'hBBBBBBBB);

        // R7 timeout (ref 4 -> 252 cycles)
        make_write(8'h2C, 7'h0C, 32'hCCCCCCCC, 4'h0);
        send_frame(4, -1, -1, -1, 0);
        idle(400);
        expect_res("R7 stalled frame dropped", 0, 0, 0);
        make_write(8'h2C, 7'h0D, 32'h0D0D0D0D, 4'h0);
        send_frame(8, -1, -1, 2, 150);
        exp_cnt++;
        expect_res("R7 gap below limit", 1, 7'h0D, 32'h0D0D0D0D);

        // R8 reference period latched from last good frame
        bit_period = 12'd20;
        make_write(8'h2C, 7'h0E, 32'h0E0E0E0E, 4'h0);
        send_frame(3, -1, -1, -1, 0);
        idle(400);
        expect_res("R8 old period governs timeout", 0, 0, 0);
        good_write("R8 load new period", 8'h2C, 7'h0F, 32'h0F0F0F0F);
        make_write(8'h2C, 7'h13, 32'h13131313, 4'h0);
        send_frame(8, -1, -1, 3, 300);
        exp_cnt++;
        expect_res("R8 new period allows long gap", 1, 7'h13, 32'h13131313);
        bit_period = 12'd4;
        good_write("R8 back to short period", 8'h2C, 7'h14, 32'h14141414);

        // Random mix
        for (int it = 0; it < 40; it++) begin
            kind = int'($urandom % 10);
            ra   = 7'($urandom);
            d    = $urandom;
            if (kind == 0) begin
                make_write(8'h2C, ra, d, 4'($urandom));
                fr[7] = fr[7] ^ (8'h01 << ($urandom % 8));
                send_frame(8, -1, -1, -1, 0);
                expect_res("R3 random bad crc", 0, 0, 0);
                idle(60);
            end else if (kind == 1) begin
                make_read(8'h2C, ra);
                send_frame(4, -1, -1, -1, 0);
                expect_res("R6 random read", 0, 0, 0);
            end else if (kind == 2) begin
                make_write(8'h2C ^ 8'(1 + ($urandom % 200)), ra, d, 4'($urandom));
                send_frame(8, -1, -1, -1, 0);
                expect_res("R4 random mismatch", 0, 0, 0);
            end else begin
                good_write("R2 random write", 8'h2C, ra, d);
            end
        end

        // R5 wrap
        while (exp_cnt != 8'hFF)
            good_write("R5 fill", 8'h2C, 7'($urandom), $urandom);
        good_write("R5 wrap write", 8'h2C, 7'h55, 32'h5555AAAA);
        chk("R5 wrapped to zero", 64'(wr_count), 64'd0);

        done = 1;
        report();
    end

endmodule